// File: doc/BRIEF.md
# Disk Drive Head Stepper Port

This block is the control port a drive controller CPU uses to move a disk head and to light the activity lamp. The CPU writes one 8-bit port register. Its two low bits are the stepper motor phase. Each write to the port compares the phase already stored with the new one, modulo 4. An advance of one phase position produces a one-clock inward step pulse. A retreat of one position produces a one-clock outward step pulse. Any other change produces no pulse. Bit 3 of the port drives the activity LED. When a write flips that bit, the block raises a one-clock update strobe, and the LED level output takes the new value.

Reads are combinational from the register index. A read of the port returns the stored bits, with two fields replaced by live inputs. Bit 7 comes from the sync detector and is cleared while sync is present. Bit 4 carries the write-protect sense. Bit 4 is always stored as zero, so the write-protect input is the only source of that bit. Index 2 holds a data-direction byte for the port. Indices 1 and 15 both return the byte on the read-data input. Every other index reads as zero and ignores writes.

Top module: `head_stepper_port`

## Requirements
- R1: While reset is asserted, and after its release with no write, the port and the direction byte read back as zero, `step_in`, `step_out` and `led_strobe` are low, and `led_level` is low.
- R2: A write to index 0 stores the written byte with bit 4 forced to 0. A read of index 0 returns `wr_protect` in bit 4 and the stored value in bits 6..5 and 3..0.
- R3: A read of index 0 returns bit 7 = 0 while `sync_det` is 1, and bit 7 = 1 while `sync_det` is 0, whatever value is stored in bit 7.
- R4: When a port write holds a new phase (bits 1..0) such that the old phase equals (new + 1) mod 4, `step_out` is high for exactly the one clock after the write. `step_in` and `step_out` are never high together.
- R5: When a port write holds a new phase such that the old phase equals (new - 1) mod 4, `step_in` is high for exactly the one clock after the write.
- R6: A port write that leaves the phase unchanged, or changes it by 2, produces no step pulse.
- R7: A port write that changes bit 3 raises `led_strobe` for exactly the one clock after the write, with `led_level` equal to the new bit 3. A port write that leaves bit 3 unchanged raises no strobe, and `led_level` keeps its value.
- R8: A read of index 1 or of index 15 returns the current value of `rd_byte`.
- R9: Index 2 stores a written byte unchanged and reads it back. Any index other than 0, 1, 2 and 15 reads as 0x00. A write to such an index leaves the port, the direction byte and every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_idx | input | 4 | Register index for reads and writes |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_idx` |
| sync_det | input | 1 | Sync-mark detector, 1 = sync present |
| wr_protect | input | 1 | Write-protect sense |
| rd_byte | input | 8 | Latest byte from the read-data path |
| step_in | output | 1 | One-clock inward step pulse |
| step_out | output | 1 | One-clock outward step pulse |
| led_strobe | output | 1 | One-clock LED update strobe |
| led_level | output | 1 | Current LED level (port bit 3) |

## Verification
The step pulses and the LED strobe are registered. They are high in the clock that follows the edge on which a port write is sampled, and they fall at the next edge unless another write re-arms them. `bus_rdata` has no register stage. It shows the stored state from the write edge onward, and it follows `sync_det`, `wr_protect`, `rd_byte` and `bus_idx` in the same cycle. The bench drives inputs on falling edges and updates its reference model on each rising edge. It compares every output 2 ns after that rising edge, once the registered outputs have changed and while the inputs are still held.

// File: rtl/hsp_pkg.sv
package hsp_pkg;

  // Step decision for one port write.
  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_IN   = 2'd1,
    STEP_OUT  = 2'd2
  } step_e;

  // Registered events sent to the pins.
  typedef struct packed {
    logic step_in;
    logic step_out;
    logic led_strobe;
  } pulse_t;

endpackage

// File: rtl/hsp_step_decode.sv
module hsp_step_decode #(
  parameter int PHASE_W = 2
) (
  input  logic [PHASE_W-1:0] old_phase,
  input  logic [PHASE_W-1:0] new_phase,
  output hsp_pkg::step_e     step_kind,
  output logic               phase_changed
);
  import hsp_pkg::*;

  // Phase one position ahead of p (wraps at 2^PHASE_W).
  function automatic logic [PHASE_W-1:0] ph_ahead(input logic [PHASE_W-1:0] p);
    logic [PHASE_W-1:0] r;
    r = p + 1'b1;
    return r;
  endfunction

  // Phase one position behind p (wraps at 2^PHASE_W).
  function automatic logic [PHASE_W-1:0] ph_behind(input logic [PHASE_W-1:0] p);
    logic [PHASE_W-1:0] r;
    r = p - 1'b1;
    return r;
  endfunction

  function automatic step_e classify(input logic [PHASE_W-1:0] o,
                                     input logic [PHASE_W-1:0] n);
    step_e r;
    if (o == n)                 r = STEP_NONE;
    else if (o == ph_ahead(n))  r = STEP_OUT;
    else if (o == ph_behind(n)) r = STEP_IN;
    else                        r = STEP_NONE;
    return r;
  endfunction

  assign phase_changed = (old_phase != new_phase);
  assign step_kind     = classify(old_phase, new_phase);

endmodule

// File: rtl/hsp_port_regs.sv
module hsp_port_regs #(
  parameter int DATA_W    = 8,
  parameter int ZERO_POS  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_port,
  input  logic              wr_dir,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] port_q,
  output logic [DATA_W-1:0] dir_q
);

  localparam logic [DATA_W-1:0] KEEP_MASK = ~(DATA_W'(1) << ZERO_POS);

  function automatic logic [DATA_W-1:0] store_form(input logic [DATA_W-1:0] d);
    return d & KEEP_MASK;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_q <= '0;
      dir_q  <= '0;
    end else begin
      if (wr_port) port_q <= store_form(wdata);
      if (wr_dir)  dir_q  <= wdata;
    end
  end

  AST_PORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_port) |-> $stable(port_q)) else $error("port changed without write"); // R9

  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_dir) |-> $stable(dir_q)) else $error("dir changed without write"); // R9

endmodule

// File: rtl/hsp_pulse_gen.sv
module hsp_pulse_gen (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_port,
  input  hsp_pkg::step_e   step_kind,
  input  logic             led_old,
  input  logic             led_new,
  output hsp_pkg::pulse_t  pulses,
  output logic             led_level
);
  import hsp_pkg::*;

  pulse_t pulse_d;

  always_comb begin
    pulse_d            = '0;
    pulse_d.step_in    = wr_port && (step_kind == STEP_IN);
    pulse_d.step_out   = wr_port && (step_kind == STEP_OUT);
    pulse_d.led_strobe = wr_port && (led_old != led_new);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulses    <= '0;
      led_level <= 1'b0;
    end else begin
      pulses <= pulse_d;
      if (pulse_d.led_strobe) led_level <= led_new;
    end
  end

  AST_STEP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(pulses.step_in && pulses.step_out)) else $error("both step pulses"); // R4

  AST_LED_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pulses.led_strobe |-> (led_level != $past(led_level))) else $error("strobe without change"); // R7

  AST_LED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !pulses.led_strobe |-> $stable(led_level)) else $error("led moved silently"); // R7

endmodule

// File: rtl/hsp_readback.sv
module hsp_readback #(
  parameter int DATA_W   = 8,
  parameter int IDX_W    = 4,
  parameter int SYNC_POS = 7,
  parameter int WP_POS   = 4,
  parameter logic [IDX_W-1:0] IDX_PORT = 0,
  parameter logic [IDX_W-1:0] IDX_DIR  = 2,
  parameter logic [IDX_W-1:0] IDX_RD_A = 1,
  parameter logic [IDX_W-1:0] IDX_RD_B = 15
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] port_q,
  input  logic [DATA_W-1:0] dir_q,
  input  logic              sync_det,
  input  logic              wr_protect,
  input  logic [DATA_W-1:0] rd_byte,
  output logic [DATA_W-1:0] rdata
);

  localparam logic [DATA_W-1:0] SYNC_BIT = DATA_W'(1) << SYNC_POS;
  localparam logic [DATA_W-1:0] WP_BIT   = DATA_W'(1) << WP_POS;

  // Port view: sync clears the top flag, absence sets it; write-protect ORed in.
  function automatic logic [DATA_W-1:0] port_view(input logic [DATA_W-1:0] p,
                                                  input logic s,
                                                  input logic w);
    logic [DATA_W-1:0] v;
    v = s ? (p & ~SYNC_BIT) : (p | SYNC_BIT);
    if (w) v = v | WP_BIT;
    return v;
  endfunction

  always_comb begin
    if (idx == IDX_PORT)                          rdata = port_view(port_q, sync_det, wr_protect);
    else if ((idx == IDX_RD_A) || (idx == IDX_RD_B)) rdata = rd_byte;
    else if (idx == IDX_DIR)                      rdata = dir_q;
    else                                          rdata = '0;
  end

endmodule

// File: rtl/head_stepper_port.sv
module head_stepper_port #(
  parameter int DATA_W   = 8,
  parameter int IDX_W    = 4,
  parameter int PHASE_W  = 2,
  parameter int LED_POS  = 3,
  parameter int WP_POS   = 4,
  parameter int SYNC_POS = 7,
  parameter logic [IDX_W-1:0] IDX_PORT = 0,
  parameter logic [IDX_W-1:0] IDX_DIR  = 2,
  parameter logic [IDX_W-1:0] IDX_RD_A = 1,
  parameter logic [IDX_W-1:0] IDX_RD_B = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [IDX_W-1:0]  bus_idx,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              sync_det,
  input  logic              wr_protect,
  input  logic [DATA_W-1:0] rd_byte,
  output logic              step_in,
  output logic              step_out,
  output logic              led_strobe,
  output logic              led_level
);
  import hsp_pkg::*;

  localparam int HALF_TURN = 1 << (PHASE_W - 1);

  // Named internal events, visible to the assertions.
  logic              wr_port;
  logic              wr_dir;
  logic [DATA_W-1:0] port_q;
  logic [DATA_W-1:0] dir_q;
  logic [PHASE_W-1:0] phase_now;
  logic [PHASE_W-1:0] phase_new;
  step_e             step_kind;
  logic              phase_changed;
  pulse_t            pulses;
  logic [PHASE_W-1:0] phase_delta;

  assign wr_port   = bus_wr && (bus_idx == IDX_PORT);
  assign wr_dir    = bus_wr && (bus_idx == IDX_DIR);
  assign phase_now = port_q[PHASE_W-1:0];
  assign phase_new = bus_wdata[PHASE_W-1:0];
  assign phase_delta = phase_new - phase_now;

  hsp_port_regs #(
    .DATA_W   (DATA_W),
    .ZERO_POS (WP_POS)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_port (wr_port),
    .wr_dir  (wr_dir),
    .wdata   (bus_wdata),
    .port_q  (port_q),
    .dir_q   (dir_q)
  );

  hsp_step_decode #(
    .PHASE_W (PHASE_W)
  ) u_decode (
    .old_phase     (phase_now),
    .new_phase     (phase_new),
    .step_kind     (step_kind),
    .phase_changed (phase_changed)
  );

  hsp_pulse_gen u_pulse (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_port   (wr_port),
    .step_kind (step_kind),
    .led_old   (port_q[LED_POS]),
    .led_new   (bus_wdata[LED_POS]),
    .pulses    (pulses),
    .led_level (led_level)
  );

  hsp_readback #(
    .DATA_W   (DATA_W),
    .IDX_W    (IDX_W),
    .SYNC_POS (SYNC_POS),
    .WP_POS   (WP_POS),
    .IDX_PORT (IDX_PORT),
    .IDX_DIR  (IDX_DIR),
    .IDX_RD_A (IDX_RD_A),
    .IDX_RD_B (IDX_RD_B)
  ) u_read (
    .idx        (bus_idx),
    .port_q     (port_q),
    .dir_q      (dir_q),
    .sync_det   (sync_det),
    .wr_protect (wr_protect),
    .rd_byte    (rd_byte),
    .rdata      (bus_rdata)
  );

  assign step_in    = pulses.step_in;
  assign step_out   = pulses.step_out;
  assign led_strobe = pulses.led_strobe;

  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (step_in || step_out) |-> $past(wr_port && phase_changed)) else $error("step without phase write"); // R5

  AST_HALF_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_port && (int'(phase_delta) == HALF_TURN)) |=> (!step_in && !step_out)) else $error("step on half turn"); // R6

  AST_STROBE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    led_strobe |-> $past(wr_port)) else $error("strobe without port write"); // R7

  AST_WP_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_idx == IDX_PORT) |-> (bus_rdata[WP_POS] == wr_protect)) else $error("wp not visible"); // R2

  AST_RD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_idx == IDX_RD_A) || (bus_idx == IDX_RD_B)) |-> (bus_rdata == rd_byte)) else $error("read data not passed"); // R8

endmodule

// File: tb/head_stepper_port_bench.sv
module head_stepper_port_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [3:0] bus_idx = 4'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       sync_det = 1'b1;
  logic       wr_protect = 1'b0;
  logic [7:0] rd_byte = 8'd0;
  logic       step_in, step_out, led_strobe, led_level;

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  head_stepper_port u_head_stepper_port (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_idx(bus_idx),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sync_det(sync_det),
    .wr_protect(wr_protect), .rd_byte(rd_byte), .step_in(step_in),
    .step_out(step_out), .led_strobe(led_strobe), .led_level(led_level)
  );

  // Reference model state
  int m_port = 0, m_dir = 0;
  bit m_sin = 0, m_sout = 0, m_led_upd = 0, m_led = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  function automatic int exp_read(input int idx);
    int v;
    if (idx == 0) begin
      v = sync_det ? (m_port & 'h7f) : (m_port | 'h80);
      if (wr_protect) v = v | 'h10;
      return v;
    end
    if (idx == 1 || idx == 15) return int'(rd_byte);
    if (idx == 2) return m_dir;
    return 0;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_port = 0; m_dir = 0; m_sin = 0; m_sout = 0; m_led_upd = 0; m_led = 0;
    end else begin
      m_sin = 0; m_sout = 0; m_led_upd = 0;
      if (bus_wr && bus_idx == 4'd0) begin
        int o, n;
        o = m_port % 4;
        n = int'(bus_wdata) % 4;
        if (o != n) begin
          if (o == (n + 1) % 4) m_sout = 1;
          else if (o == (n + 3) % 4) m_sin = 1;
        end
        if (((m_port >> 3) & 1) != int'(bus_wdata[3])) begin
          m_led_upd = 1;
          m_led = bus_wdata[3];
        end
        m_port = int'(bus_wdata) & 'hef;
      end
      if (bus_wr && bus_idx == 4'd2) m_dir = int'(bus_wdata);
    end
    #2;
    chk("R4 step_out", int'(step_out), int'(m_sout));
    chk("R5 step_in", int'(step_in), int'(m_sin));
    chk("R7 led_strobe", int'(led_strobe), int'(m_led_upd));
    chk("R7 led_level", int'(led_level), int'(m_led));
    if (bus_idx == 4'd0)
      chk("R2 R3 port read", int'(bus_rdata), exp_read(0));
    else if (bus_idx == 4'd1 || bus_idx == 4'd15)
      chk("R8 read data", int'(bus_rdata), exp_read(int'(bus_idx)));
    else
      chk("R9 other index", int'(bus_rdata), exp_read(int'(bus_idx)));
  end

  task automatic cyc_drive(input bit wr, input int idx, input int d,
                           input bit s, input bit w, input int rb);
    @(negedge clk);
    bus_wr = wr; bus_idx = 4'(idx); bus_wdata = 8'(d);
    sync_det = s; wr_protect = w; rd_byte = 8'(rb);
  endtask

  task automatic wport(input int d);
    cyc_drive(1, 0, d, 1, 0, 0);
    cyc_drive(0, 0, 0, 1, 0, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired, actual 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: state after reset, no write yet
    cyc_drive(0, 0, 0, 1, 0, 0);
    @(posedge clk); #3;
    chk("R1 port zero", int'(bus_rdata), 0);
    chk("R1 no pulse", int'({step_in, step_out, led_strobe, led_level}), 0);
    cyc_drive(0, 2, 0, 1, 0, 0);
    @(posedge clk); #3;
    chk("R1 dir zero", int'(bus_rdata), 0);
    // R5: walking inward 0->1->2->3->0
    wport(1); wport(2); wport(3); wport(0);
    // R4: walking outward 0->3->2->1->0
    wport(3); wport(2); wport(1); wport(0);
    // R6: half turns and no change
    wport(2); wport(0); wport(0); wport(1); wport(3);
    // R4 R5 back-to-back writes
    cyc_drive(1, 0, 0, 1, 0, 0);
    cyc_drive(1, 0, 1, 1, 0, 0);
    cyc_drive(1, 0, 2, 1, 0, 0);
    cyc_drive(1, 0, 1, 1, 0, 0);
    // R7: LED on, repeat, off
    wport('h08); wport('h09); wport('h01);
    // R2: bit 4 written as 1 is dropped; wp shows on read
    wport('hff);
    cyc_drive(0, 0, 0, 0, 1, 0);
    cyc_drive(0, 0, 0, 1, 1, 0);
    cyc_drive(0, 0, 0, 0, 0, 0);
    // R3: stored bit 7 clear, sync toggled
    wport('h21);
    cyc_drive(0, 0, 0, 0, 0, 0);
    cyc_drive(0, 0, 0, 1, 0, 0);
    // R8: read-data indices
    cyc_drive(0, 1, 0, 1, 0, 'h5a);
    cyc_drive(0, 15, 0, 1, 0, 'ha5);
    cyc_drive(0, 1, 0, 1, 0, 'h00);
    // R9: direction register and ignored indices
    cyc_drive(1, 2, 'hc3, 1, 0, 0);
    cyc_drive(0, 2, 0, 1, 0, 0);
    for (int i = 3; i < 15; i++) begin
      cyc_drive(1, i, 'hff - i, 1, 0, 0);
      cyc_drive(0, i, 0, 1, 0, 0);
    end
    cyc_drive(0, 0, 0, 1, 1, 0);
    cyc_drive(0, 2, 0, 1, 0, 0);
    // Mixed traffic from a fixed pseudo-random sequence
    begin
      int lf = 'h1d3;
      for (int k = 0; k < 300; k++) begin
        lf = ((lf << 1) ^ (((lf >> 8) ^ (lf >> 4)) & 1)) & 'h1ff;
        cyc_drive(lf[0] | lf[3], (lf[2:1] == 2'd3) ? 15 : int'(lf[2:1]),
                  (lf * 37) & 'hff, lf[5], lf[6], (lf * 11) & 'hff);
      end
    end
    cyc_drive(0, 0, 0, 1, 0, 0);
    repeat (2) @(posedge clk);
    #4;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule